// File: doc/BRIEF.md
# NAND Block Hamming ECC Generator

This unit sits next to the data register of a NAND flash controller and watches every byte that passes through it, whether the byte is written toward the flash or read back from it. While the unit is set to accumulate, each byte is folded into a Hamming-style parity code, and its position within a 256-byte block is counted. The result is a 3-byte code for each block. Software uses that code later to detect and correct single-bit errors. Correction itself is outside this unit.

Software controls the unit through a 2-bit mode field: clear, idle, accumulate and readout. A block starts with the sequence clear, idle, accumulate. To fetch the code, software sets idle, then readout, performs three data-register reads, and sets idle again. While readout is selected, a data-register read returns a code byte from an internal pointer instead of flash data, and it starts no flash strobe.

Top module: `nand_ecc_gen`

## Requirements
- R1: While `mode_i` is 2'b11 (clear), the next clock edge zeroes the raw parity, the byte index and the readout pointer. The code then reads 0xFF, 0xFF, 0xFF. Clearing takes priority over any data transfer in the same cycle.
- R2: With `mode_i` = 2'b01 (accumulate), each cycle with `dat_wr_i` or `dat_rd_i` high and both `cle_i` and `ale_i` low folds one byte into the code. The byte is `wdata_i` on a write and `fdata_i` on a read. A cycle with `cle_i` or `ale_i` high folds nothing.
- R3: With `mode_i` at 2'b00 (idle) or 2'b10 (readout), transfers leave the code and the byte index unchanged.
- R4: For byte parity p at 8-bit index i, the unit XORs p into even line bit k when bit k of i is 0, and into odd line bit k when it is 1. Code byte 0 holds the line bits for index bits 3..0 and code byte 1 holds those for index bits 7..4. Within each byte, bit 2k is the even line bit and bit 2k+1 is the odd line bit. All code bits are output inverted. A single 0x01 at index 0 gives byte0 = byte1 = 0xAA. A single 0x80 at index 255 gives byte0 = byte1 = 0x55.
- R5: Column parity bit k (k = 0..2) is the XOR of the data bits whose bit position has bit k clear (even) or set (odd). Code byte 2 holds these in bits 7:2, ordered {odd2, even2, odd1, even1, odd0, even0}. They are inverted, and bits 1:0 of byte 2 always read 1. A single 0x01 gives 0xAB and a single 0x80 gives 0x57.
- R6: A block of 256 bytes of 0xFF gives the code 0xFF, 0xFF, 0xFF.
- R7: In readout mode, successive data-register reads return code byte 1, then byte 0, then byte 2, and then the order starts again with byte 1.
- R8: `strobe_o` is high for any data write, and for any data read outside readout mode. Outside readout mode, `rdata_o` equals `fdata_i`. A data read in readout mode leaves `strobe_o` low.
- R9: The byte index wraps after 256 folded bytes, so the 257th byte counts as index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | ECC mode field: 00 idle, 01 accumulate, 10 readout, 11 clear |
| cle_i | input | 1 | Command latch enable currently driven to flash |
| ale_i | input | 1 | Address latch enable currently driven to flash |
| dat_wr_i | input | 1 | One-cycle data-register write |
| dat_rd_i | input | 1 | One-cycle data-register read |
| wdata_i | input | 8 | Byte written to the data register |
| fdata_i | input | 8 | Byte returned by flash for the current read |
| rdata_o | output | 8 | Data-register read value: code byte in readout mode, flash byte otherwise |
| strobe_o | output | 1 | Request to start a flash strobe cycle |

## Verification
Two functions can fall in the same cycle. A transfer can arrive while the mode field holds the clear code, and a readout read both returns a code byte and moves the pointer while it suppresses the strobe. The bench issues a data write while clear is selected and requires the next readout to show an erased code. It then reads the code more than three times in a row to check that the pointer wraps, and checks `strobe_o` on every one of those reads. Random blocks mix command and address cycles, idle gaps and reads with writes. Each block is compared against a bench model of the parity rules.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    ECC_IDLE = 2'b00,
    ECC_ACC  = 2'b01,
    ECC_READ = 2'b10,
    ECC_CLR  = 2'b11
  } ecc_mode_e;

  localparam int unsigned CODE_BYTES = 3;
endpackage

// File: rtl/nand_ecc_fold.sv
module nand_ecc_fold #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned POS_W = $clog2(DATA_W),
  localparam int unsigned LP_W  = 2 * IDX_W,
  localparam int unsigned CP_W  = 2 * POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fold_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [LP_W-1:0]   lp_o,
  output logic [CP_W-1:0]   cp_o
);
  logic [IDX_W-1:0] idx_q;
  logic [LP_W-1:0]  lp_q, lp_mask;
  logic [CP_W-1:0]  cp_q, cp_mask;
  logic             byte_par;

  assign byte_par = ^byte_i;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lp_mask[2*k]   = byte_par & ~idx_q[k];
    assign lp_mask[2*k+1] = byte_par &  idx_q[k];
  end

  always_comb begin
    cp_mask = '0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int k = 0; k < POS_W; k++) begin
        cp_mask[2*k + ((j >> k) & 1)] = cp_mask[2*k + ((j >> k) & 1)] ^ byte_i[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      lp_q  <= '0;
      cp_q  <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      lp_q  <= '0;
      cp_q  <= '0;
    end else if (fold_i) begin
      idx_q <= idx_q + 1'b1;
      lp_q  <= lp_q ^ lp_mask;
      cp_q  <= cp_q ^ cp_mask;
    end
  end

  assign lp_o = lp_q;
  assign cp_o = cp_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lp_q == '0 && cp_q == '0 && idx_q == '0)); // R1
  AST_HOLD_NOFOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !fold_i) |=> ($stable(lp_q) && $stable(cp_q) && $stable(idx_q))); // R3
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && fold_i) |=> idx_q == $past(idx_q) + 1'b1); // R9
endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout #(
  parameter int unsigned LP_W = 16,
  parameter int unsigned CP_W = 6,
  localparam int unsigned CODE_W = 8 * nand_ecc_pkg::CODE_BYTES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [LP_W-1:0] lp_i,
  input  logic [CP_W-1:0] cp_i,
  output logic [7:0]      code_byte_o
);
  logic [1:0]        ptr_q;
  logic [CODE_W-1:0] code;
  logic [1:0]        sel;

  // raw zero pads become ones after inversion
  assign code = ~{cp_i, {(CODE_W-LP_W-CP_W){1'b0}}, lp_i};

  always_comb begin
    unique case (ptr_q)
      2'd0:    sel = 2'd1;
      2'd1:    sel = 2'd0;
      default: sel = 2'd2;
    endcase
  end

  assign code_byte_o = code[8*sel +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == 2'd2) ? 2'd0 : ptr_q + 2'd1;
  end

  AST_PTR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q != 2'd3); // R7
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && ptr_q == 2'd2) |=> ptr_q == 2'd0); // R7
  AST_PTR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_q == 2'd0); // R1
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int unsigned IDX_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       dat_wr_i,
  input  logic       dat_rd_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] fdata_i,
  output logic [7:0] rdata_o,
  output logic       strobe_o
);
  import nand_ecc_pkg::*;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned LP_W   = 2 * IDX_W;
  localparam int unsigned CP_W   = 2 * $clog2(DATA_W);

  ecc_mode_e   mode;
  logic        clr, fold, rd_code, xfer;
  logic [7:0]  snoop, code_byte;
  logic [LP_W-1:0] lp;
  logic [CP_W-1:0] cp;

  assign mode    = ecc_mode_e'(mode_i);
  assign xfer    = dat_wr_i | dat_rd_i;
  assign clr     = (mode == ECC_CLR);
  assign fold    = (mode == ECC_ACC) && xfer && !cle_i && !ale_i;
  assign rd_code = (mode == ECC_READ) && dat_rd_i;
  assign snoop   = dat_wr_i ? wdata_i : fdata_i;

  nand_ecc_fold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fold (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .fold_i (fold),
    .byte_i (snoop),
    .lp_o   (lp),
    .cp_o   (cp)
  );

  nand_ecc_readout #(.LP_W(LP_W), .CP_W(CP_W)) u_rdout (
    .clk_i, .rst_ni,
    .clr_i       (clr),
    .adv_i       (rd_code),
    .lp_i        (lp),
    .cp_i        (cp),
    .code_byte_o (code_byte)
  );

  assign rdata_o  = (mode == ECC_READ) ? code_byte : fdata_i;
  assign strobe_o = dat_wr_i | (dat_rd_i & (mode != ECC_READ));

  AST_NO_STROBE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && dat_rd_i && !dat_wr_i) |-> !strobe_o); // R8
  AST_CMD_NOFOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && (cle_i || ale_i)) |=> $stable(lp) && $stable(cp)); // R2
endmodule

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic       cle = 0, ale = 0, wr = 0, rd = 0;
  logic [7:0] wdata = 0, fdata = 0, rdata;
  logic       strobe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_lp;
  logic [5:0]  m_cp;
  logic [7:0]  m_idx;

  nand_ecc_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cle_i(cle), .ale_i(ale),
    .dat_wr_i(wr), .dat_rd_i(rd), .wdata_i(wdata), .fdata_i(fdata),
    .rdata_o(rdata), .strobe_o(strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] m_code();
    return ~{m_cp, 2'b00, m_lp};
  endfunction

  task automatic m_clear();
    m_lp = '0; m_cp = '0; m_idx = '0;
  endtask

  task automatic m_fold(input logic [7:0] d);
    logic p;
    p = ^d;
    for (int k = 0; k < 8; k++)
      if (p) m_lp[2*k + (m_idx[k] ? 1 : 0)] ^= 1'b1;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 3; k++)
        if (d[j]) m_cp[2*k + ((j >> k) & 1)] ^= 1'b1;
    m_idx++;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m; wr = 0; rd = 0; cle = 0; ale = 0;
    @(posedge clk);
    if (m == 2'b11) m_clear();
  endtask

  // one transfer in the current mode
  task automatic xfer(input bit is_wr, input logic [7:0] d, input bit c, input bit a);
    @(negedge clk);
    wr = is_wr; rd = !is_wr; cle = c; ale = a;
    if (is_wr) wdata = d; else fdata = d;
    #1;
    if (mode != 2'b10) begin
      chk("R8 strobe", {7'd0, strobe}, 8'd1);
      if (!is_wr) chk("R8 rdata passthrough", rdata, d);
    end
    @(posedge clk);
    if (mode == 2'b11) m_clear();
    else if (mode == 2'b01 && !c && !a) m_fold(d);
  endtask

  task automatic read_code(input string req, input int n);
    logic [23:0] c;
    set_mode(2'b00);
    set_mode(2'b10);
    c = m_code();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr = 0; rd = 1; fdata = $urandom;
      #1;
      case (i % 3)
        0: chk({req, " R7 byte1"}, rdata, c[15:8]);
        1: chk({req, " R7 byte0"}, rdata, c[7:0]);
        default: chk({req, " R7 byte2"}, rdata, c[23:16]);
      endcase
      chk("R8 no strobe in readout", {7'd0, strobe}, 8'd0);
      @(posedge clk);
    end
    set_mode(2'b00);
  endtask

  task automatic start_block();
    set_mode(2'b11); set_mode(2'b00); set_mode(2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0ec5));
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset state: code erased, passthrough outside readout
    read_code("R1 after reset", 3);

    // single 0x01 at index 0
    start_block();
    xfer(1, 8'h01, 0, 0);
    read_code("R4 R5 single 0x01", 3);
    chk("R4 const byte0", m_code()[7:0], 8'hAA);
    chk("R5 const byte2", m_code()[23:16], 8'hAB);

    // 0x80 at index 255
    start_block();
    for (int i = 0; i < 255; i++) xfer(i % 2, 8'h00, 0, 0);
    xfer(1, 8'h80, 0, 0);
    read_code("R4 R5 0x80 at 255", 3);
    chk("R4 const byte1", m_code()[15:8], 8'h55);
    chk("R5 const byte2b", m_code()[23:16], 8'h57);

    // erased block then index wrap
    start_block();
    for (int i = 0; i < 256; i++) xfer(i % 3 == 0, 8'hFF, 0, 0);
    read_code("R6 erased", 3);
    chk("R6 const", m_code()[7:0], 8'hFF);
    set_mode(2'b01);
    xfer(1, 8'h01, 0, 0);
    read_code("R9 wrap to index0", 3);
    chk("R9 const", m_code()[15:8], 8'hAA);

    // command/address cycles ignored, idle ignored
    start_block();
    xfer(1, 8'h5A, 1, 0);
    xfer(1, 8'h33, 0, 1);
    set_mode(2'b00);
    xfer(0, 8'h7E, 0, 0);
    read_code("R2 R3 ignored", 3);

    // transfer during clear: clear wins
    start_block();
    xfer(1, 8'hC3, 0, 0);
    set_mode(2'b11);
    xfer(1, 8'h01, 0, 0);
    read_code("R1 clear with write", 3);

    // pointer wrap over seven reads
    start_block();
    xfer(0, 8'h96, 0, 0);
    xfer(1, 8'h0F, 0, 0);
    read_code("R7 wrap", 7);

    // random blocks
    for (int b = 0; b < 8; b++) begin
      int n;
      start_block();
      n = 100 + ($urandom % 200);
      for (int i = 0; i < n; i++) begin
        int r;
        r = $urandom % 16;
        if (r == 0) begin
          set_mode(2'b00);
          xfer($urandom % 2, $urandom, 0, 0);
          set_mode(2'b01);
        end else begin
          xfer($urandom % 2, $urandom, (r == 1), (r == 2));
        end
      end
      read_code("R2 R4 R5 random", 3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule